// File: doc/BRIEF.md
# Rotated Tiled View Address Generator

This unit turns a pixel position inside a two-dimensional tiled container into a 32-bit address in tiled address space. The caller supplies a pixel format (8-bit, 16-bit, 32-bit or page), a three-bit view orientation code and an x/y coordinate. The unit checks each coordinate against the field width that the format allows. It optionally mirrors either axis and optionally transposes the two axes. It then packs the resulting linear index together with the format and orientation tags into one address word.

Alongside the address it reports whether the coordinate was in range, and the line stride in bytes of the selected view. Display and video engines use the stride to walk a rotated or mirrored view one line at a time. Each request is taken on a clock edge when the request strobe is high. The results appear on the outputs one cycle later and stay there until the next request.

Top module: `tiled_view_addr`

## Requirements
- R1: A request sampled with `req_i` high appears on `addr_o`, `addr_ok_o` and `stride_o` after the next rising clock edge, one cycle of latency. In a cycle where `req_i` is low, `addr_o` and `stride_o` keep their values and `addr_ok_o` goes low.
- R2: Address bits [28:27] carry the format code: 0 is 8-bit, 1 is 16-bit, 2 is 32-bit, 3 is page.
- R3: Address bits [31:29] carry the orientation code unchanged. Bit 29 requests Y mirroring, bit 30 requests X mirroring and bit 31 requests the X/Y swap.
- R4: If x or y lies above its field maximum, `addr_o` is 0 and `addr_ok_o` is low. Otherwise `addr_ok_o` is high.
- R5: The per-format shift pairs (x_shift, y_shift) are 8-bit (0,0), 16-bit (0,1), 32-bit (1,1) and page (6,6). The x field is 14 - x_shift bits wide and the y field is 13 - y_shift bits wide. So the largest legal x/y are 16383/8191, 16383/4095, 8191/4095 and 255/127.
- R6: Mirroring an axis XORs that coordinate with its field's all-ones mask. It is applied before any swap.
- R7: Without swap the index is (y << x_bits) + x. The index is shifted left by x_shift + y_shift and placed in bits [26:0].
- R8: With swap the index is (x << y_bits) + y, with the same shift and placement as R7.
- R9: `stride_o` is 1 << (13 + x_shift) when swap is requested and 1 << (14 + y_shift) otherwise. It is updated on every request, including one that is out of range.
- R10: While reset is asserted and after it, until the first request, `addr_o`, `stride_o` and `addr_ok_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request strobe; samples the inputs below |
| fmt_i | input | 2 | Pixel format code |
| orient_i | input | 3 | Orientation code (Y mirror, X mirror, swap) |
| x_i | input | 16 | Pixel column |
| y_i | input | 16 | Pixel row |
| addr_o | output | 32 | Tiled-space address |
| addr_ok_o | output | 1 | Coordinate was in range for the last request |
| stride_o | output | 32 | Line stride of the selected view in bytes |

## Verification
The hardest case to reach is a mirror combined with a swap. An error in the order of the two operations, or a mirror applied with the other axis's mask, is only visible when the two field widths differ and the coordinate lies near a field edge. The stimulus therefore uses hand-worked vectors for the 32-bit and page formats with swap and mirror set together. A sweep over all format and orientation pairs follows. Range limits are then hit exactly at the field maximum and one above it, for every format.

// File: rtl/tva_pkg.sv
package tva_pkg;

  typedef enum logic [1:0] {
    FMT_B8   = 2'd0,
    FMT_B16  = 2'd1,
    FMT_B32  = 2'd2,
    FMT_PAGE = 2'd3
  } fmt_e;

  localparam int ORI_YINV = 0;
  localparam int ORI_XINV = 1;
  localparam int ORI_SWAP = 2;

  localparam int SH_W = 5;

  typedef struct packed {
    logic [SH_W-1:0] xs;
    logic [SH_W-1:0] ys;
  } shift_t;

endpackage

// File: rtl/tva_geom.sv
module tva_geom
  import tva_pkg::*;
#(
  parameter int CW_BITS     = 14,
  parameter int CH_BITS     = 13,
  parameter int SLOT_W_BITS = 6,
  parameter int SLOT_H_BITS = 6
) (
  input  logic [1:0]      fmt_i,
  output shift_t          shift_o,
  output logic [SH_W-1:0] x_bits_o,
  output logic [SH_W-1:0] y_bits_o,
  output logic [31:0]     x_mask_o,
  output logic [31:0]     y_mask_o
);

  localparam logic [SH_W-1:0] CW_L = SH_W'(CW_BITS);
  localparam logic [SH_W-1:0] CH_L = SH_W'(CH_BITS);

  always_comb begin
    unique case (fmt_e'(fmt_i))
      FMT_B8:   shift_o = '{xs: SH_W'(0), ys: SH_W'(0)};
      FMT_B16:  shift_o = '{xs: SH_W'(0), ys: SH_W'(1)};
      FMT_B32:  shift_o = '{xs: SH_W'(1), ys: SH_W'(1)};
      default:  shift_o = '{xs: SH_W'(SLOT_W_BITS), ys: SH_W'(SLOT_H_BITS)};
    endcase
  end

  always_comb begin
    x_bits_o = CW_L - shift_o.xs;
    y_bits_o = CH_L - shift_o.ys;
    x_mask_o = (32'd1 << x_bits_o) - 32'd1;
    y_mask_o = (32'd1 << y_bits_o) - 32'd1;
  end

endmodule

// File: rtl/tva_xform.sv
module tva_xform
  import tva_pkg::*;
#(
  parameter int COORD_W = 16
) (
  input  logic [COORD_W-1:0] x_i,
  input  logic [COORD_W-1:0] y_i,
  input  logic [2:0]         orient_i,
  input  logic [SH_W-1:0]    x_bits_i,
  input  logic [SH_W-1:0]    y_bits_i,
  input  logic [31:0]        x_mask_i,
  input  logic [31:0]        y_mask_i,
  output logic               in_range_o,
  output logic [31:0]        lin_o
);

  localparam int PAD = 32 - COORD_W;

  logic [31:0] x_ext, y_ext;
  logic [31:0] x_mir, y_mir;

  always_comb begin
    x_ext = {{PAD{1'b0}}, x_i};
    y_ext = {{PAD{1'b0}}, y_i};
    in_range_o = (x_ext <= x_mask_i) && (y_ext <= y_mask_i);
  end

  // mirror first, in each axis's own field
  always_comb begin
    x_mir = orient_i[ORI_XINV] ? (x_ext ^ x_mask_i) : x_ext;
    y_mir = orient_i[ORI_YINV] ? (y_ext ^ y_mask_i) : y_ext;
  end

  // then optional transpose into a linear index
  always_comb begin
    if (orient_i[ORI_SWAP]) lin_o = (x_mir << y_bits_i) + y_mir;
    else                    lin_o = (y_mir << x_bits_i) + x_mir;
  end

endmodule

// File: rtl/tva_pack.sv
module tva_pack
  import tva_pkg::*;
#(
  parameter int CW_BITS = 14,
  parameter int CH_BITS = 13,
  parameter int AREA_W  = CW_BITS + CH_BITS,
  parameter int ADDR_W  = AREA_W + 5
) (
  input  logic [31:0]       lin_i,
  input  shift_t            shift_i,
  input  logic [1:0]        fmt_i,
  input  logic [2:0]        orient_i,
  input  logic              in_range_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [31:0]       stride_o
);

  localparam logic [SH_W-1:0] CW_L = SH_W'(CW_BITS);
  localparam logic [SH_W-1:0] CH_L = SH_W'(CH_BITS);

  logic [SH_W-1:0] align;
  logic [31:0]     placed;

  always_comb begin
    align  = shift_i.xs + shift_i.ys;
    placed = lin_i << align;
    if (in_range_i) addr_o = {orient_i, fmt_i, placed[AREA_W-1:0]};
    else            addr_o = '0;
  end

  always_comb begin
    if (orient_i[ORI_SWAP]) stride_o = 32'd1 << (CH_L + shift_i.xs);
    else                    stride_o = 32'd1 << (CW_L + shift_i.ys);
  end

endmodule

// File: rtl/tiled_view_addr.sv
module tiled_view_addr
  import tva_pkg::*;
#(
  parameter int CW_BITS     = 14,
  parameter int CH_BITS     = 13,
  parameter int SLOT_W_BITS = 6,
  parameter int SLOT_H_BITS = 6,
  parameter int COORD_W     = 16,
  localparam int AREA_W     = CW_BITS + CH_BITS,
  localparam int ADDR_W     = AREA_W + 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_i,
  input  logic [1:0]         fmt_i,
  input  logic [2:0]         orient_i,
  input  logic [COORD_W-1:0] x_i,
  input  logic [COORD_W-1:0] y_i,
  output logic [ADDR_W-1:0]  addr_o,
  output logic               addr_ok_o,
  output logic [31:0]        stride_o
);

  shift_t          shift;
  logic [SH_W-1:0] x_bits, y_bits;
  logic [31:0]     x_mask, y_mask;
  logic            in_range;
  logic [31:0]     lin;
  logic [ADDR_W-1:0] addr_c;
  logic [31:0]     stride_c;

  tva_geom #(
    .CW_BITS(CW_BITS), .CH_BITS(CH_BITS),
    .SLOT_W_BITS(SLOT_W_BITS), .SLOT_H_BITS(SLOT_H_BITS)
  ) u_geom (
    .fmt_i(fmt_i), .shift_o(shift),
    .x_bits_o(x_bits), .y_bits_o(y_bits),
    .x_mask_o(x_mask), .y_mask_o(y_mask)
  );

  tva_xform #(.COORD_W(COORD_W)) u_xform (
    .x_i(x_i), .y_i(y_i), .orient_i(orient_i),
    .x_bits_i(x_bits), .y_bits_i(y_bits),
    .x_mask_i(x_mask), .y_mask_i(y_mask),
    .in_range_o(in_range), .lin_o(lin)
  );

  tva_pack #(
    .CW_BITS(CW_BITS), .CH_BITS(CH_BITS),
    .AREA_W(AREA_W), .ADDR_W(ADDR_W)
  ) u_pack (
    .lin_i(lin), .shift_i(shift), .fmt_i(fmt_i), .orient_i(orient_i),
    .in_range_i(in_range), .addr_o(addr_c), .stride_o(stride_c)
  );

  // output stage: next-state then register
  logic [ADDR_W-1:0] addr_d, addr_q;
  logic [31:0]       stride_d, stride_q;
  logic              ok_d, ok_q;

  always_comb begin
    addr_d   = addr_q;
    stride_d = stride_q;
    ok_d     = 1'b0;
    if (req_i) begin
      addr_d   = addr_c;
      stride_d = stride_c;
      ok_d     = in_range;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      stride_q <= '0;
      ok_q     <= 1'b0;
    end else begin
      addr_q   <= addr_d;
      stride_q <= stride_d;
      ok_q     <= ok_d;
    end
  end

  assign addr_o    = addr_q;
  assign stride_o  = stride_q;
  assign addr_ok_o = ok_q;

  // R1: idle cycles keep address and stride, and drop the ok flag
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> ($stable(addr_o) && $stable(stride_o) && !addr_ok_o));

  // R2, R3: tag bits follow the request's format and orientation
  p_tags_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && in_range) |=>
      (addr_o[ADDR_W-1 -: 5] == $past({orient_i, fmt_i})) && addr_ok_o);

  // R4: rejected coordinate yields a zero address
  p_zero_bad_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !in_range) |=> (addr_o == '0) && !addr_ok_o);

  // R7: the linear index fits in the combined field widths
  p_lin_fits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && in_range) |-> ((lin >> (x_bits + y_bits)) == 32'd0));

  // R9: stride is a single power of two after any request
  p_stride_pow2_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> ($countones(stride_o) == 1));

endmodule

// File: tb/tb_tiled_view_addr.sv
module tb_tiled_view_addr;

  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, req;
  logic [1:0]  fmt;
  logic [2:0]  ori;
  logic [15:0] x, y;
  logic [31:0] addr, stride;
  logic        ok;

  int checks = 0;
  int errors = 0;

  tiled_view_addr dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .fmt_i(fmt), .orient_i(ori),
    .x_i(x), .y_i(y), .addr_o(addr), .addr_ok_o(ok), .stride_o(stride)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  typedef struct packed {
    logic [1:0]  f;
    logic [2:0]  o;
    logic [15:0] vx;
    logic [15:0] vy;
    logic [31:0] e_addr;
    logic        e_ok;
    logic [31:0] e_stride;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 3'd0, 16'd5,     16'd3,    32'h0000C005, 1'b1, 32'h00004000},
    '{2'd2, 3'd6, 16'd1,     16'd2,    32'hD7FF8008, 1'b1, 32'h00004000},
    '{2'd3, 3'd1, 16'd255,   16'd0,    32'h3FFFF000, 1'b1, 32'h00100000},
    '{2'd1, 3'd0, 16'd0,     16'd4096, 32'h00000000, 1'b0, 32'h00008000},
    '{2'd1, 3'd0, 16'd16383, 16'd4095, 32'h0FFFFFFE, 1'b1, 32'h00008000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // independent reference from the requirements
  function automatic void shifts(input logic [1:0] f, output int xs, output int ys);
    case (f)
      2'd0: begin xs = 0; ys = 0; end
      2'd1: begin xs = 0; ys = 1; end
      2'd2: begin xs = 1; ys = 1; end
      default: begin xs = 6; ys = 6; end
    endcase
  endfunction

  function automatic logic ref_ok(input logic [1:0] f, input int vx, input int vy);
    int xs, ys;
    shifts(f, xs, ys);
    return (vx < (1 << (14 - xs))) && (vy < (1 << (13 - ys)));
  endfunction

  function automatic logic [31:0] ref_addr(input logic [1:0] f, input logic [2:0] o,
                                           input int vx, input int vy);
    int xs, ys, xb, yb, mx, my;
    longint idx;
    shifts(f, xs, ys);
    xb = 14 - xs; yb = 13 - ys;
    if (!ref_ok(f, vx, vy)) return 32'd0;
    mx = o[1] ? (((1 << xb) - 1) - vx) : vx;
    my = o[0] ? (((1 << yb) - 1) - vy) : vy;
    idx = o[2] ? (longint'(mx) * (1 << yb) + my) : (longint'(my) * (1 << xb) + mx);
    idx = idx * (longint'(1) << (xs + ys));
    return {o, f, idx[26:0]};
  endfunction

  function automatic logic [31:0] ref_stride(input logic [1:0] f, input logic [2:0] o);
    int xs, ys;
    shifts(f, xs, ys);
    return o[2] ? (32'd1 << (13 + xs)) : (32'd1 << (14 + ys));
  endfunction

  task automatic issue(input logic [1:0] f, input logic [2:0] o,
                       input logic [15:0] vx, input logic [15:0] vy);
    @(negedge clk);
    fmt = f; ori = o; x = vx; y = vy; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  initial begin
    logic [31:0] a_hold, s_hold;
    rst_n = 1'b0; req = 1'b0; fmt = 2'd0; ori = 3'd0; x = '0; y = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 addr in reset", addr, 32'd0);
    chk("R10 ok in reset", {31'd0, ok}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 stride after reset", stride, 32'd0);
    chk("R10 addr after reset", addr, 32'd0);

    // hand-worked table: R6 R7 R8 R4 R2 R3 R9
    for (int i = 0; i < NV; i++) begin
      issue(VECS[i].f, VECS[i].o, VECS[i].vx, VECS[i].vy);
      chk("R7 R8 R6 table addr", addr, VECS[i].e_addr);
      chk("R4 table ok", {31'd0, ok}, {31'd0, VECS[i].e_ok});
      chk("R9 table stride", stride, VECS[i].e_stride);
    end

    // R1: hold while idle, inputs changed
    a_hold = addr; s_hold = stride;
    @(negedge clk);
    fmt = 2'd3; ori = 3'd7; x = 16'd9; y = 16'd9;
    @(negedge clk);
    chk("R1 addr held", addr, a_hold);
    chk("R1 stride held", stride, s_hold);
    chk("R1 ok low when idle", {31'd0, ok}, 32'd0);

    // sweep every format and orientation: R2 R3 R6 R7 R8 R9
    for (int f = 0; f < 4; f++) begin
      for (int o = 0; o < 8; o++) begin
        int vx, vy;
        vx = 17 * o + 3 * f + 1;
        vy = 5 * o + f + 2;
        issue(2'(f), 3'(o), 16'(vx), 16'(vy));
        chk("R2 R3 sweep addr", addr, ref_addr(2'(f), 3'(o), vx, vy));
        chk("R9 sweep stride", stride, ref_stride(2'(f), 3'(o)));
      end
    end

    // R5 and R4: field maxima and one beyond, per format
    for (int f = 0; f < 4; f++) begin
      int xs, ys, xm, ym;
      shifts(2'(f), xs, ys);
      xm = (1 << (14 - xs)) - 1;
      ym = (1 << (13 - ys)) - 1;
      issue(2'(f), 3'd7, 16'(xm), 16'(ym));
      chk("R5 max ok", {31'd0, ok}, 32'd1);
      chk("R5 max addr", addr, ref_addr(2'(f), 3'd7, xm, ym));
      issue(2'(f), 3'd0, 16'(xm + 1), 16'd0);
      chk("R5 x over ok", {31'd0, ok}, 32'd0);
      chk("R4 x over addr", addr, 32'd0);
      issue(2'(f), 3'd4, 16'd0, 16'(ym + 1));
      chk("R5 y over ok", {31'd0, ok}, 32'd0);
      chk("R9 stride on rejected", stride, ref_stride(2'(f), 3'd4));
    end

    // R1: back-to-back requests each appear one cycle later
    @(negedge clk);
    fmt = 2'd0; ori = 3'd0; x = 16'd1; y = 16'd0; req = 1'b1;
    @(negedge clk);
    chk("R1 first of pair", addr, 32'h00000001);
    x = 16'd2;
    @(negedge clk);
    req = 1'b0;
    chk("R1 second of pair", addr, 32'h00000002);

    // R10: reset mid-run clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10 reset clears addr", addr, 32'd0);
    chk("R10 reset clears stride", stride, 32'd0);
    rst_n = 1'b1;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule